// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block lets a two-wire (I2C) bus master read and write a byte-wide non-volatile store. A fast system clock oversamples the bus clock and data lines and recognises START and STOP conditions. It accepts a device byte, which holds a type code, three select bits and the transfer direction. It then takes a two-byte word address and either collects data bytes for a page write or streams stored bytes back to the master.

The array holds 2^ADDR_W bytes. The default is 2048 bytes; ADDR_W = 14 gives 16384 bytes. Address bits in the two address bytes that lie above ADDR_W are ignored. Written bytes go into a page staging buffer first. After the STOP they are copied into the array by a write cycle that lasts TWR_CYCLES system clocks. The block answers no device byte during that time. A protect input discards writes without disturbing the handshake. The data line is never driven high: the block only asserts a pull-low enable.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_oe_o` is 0. Bus clocking that is not preceded by a START (SDA falling while SCL is high) is never acknowledged.
- R2: A device byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal `dev_sel_i`. Acknowledge means `sda_oe_o` = 1 during the ninth SCL pulse, and `sda_oe_o` changes only while SCL is low.
- R3: After a write device byte (bit 0 = 0), the next two bytes form the word address, high byte first. Address bits at or above ADDR_W have no effect.
- R4: A byte written to address A and committed can be read back with a selective read: write device byte, two address bytes, repeated START, read device byte (bit 0 = 1).
- R5: In a read, each master ACK (SDA low on the ninth pulse) makes the block send the byte at the next address. The address wraps from 2^ADDR_W-1 to 0.
- R6: During a write, successive data bytes go to successive addresses in which only the low PAGE_W bits advance, wrapping inside the same page.
- R7: Data bytes are committed only after a STOP. For TWR_CYCLES clocks after that STOP, no device byte is acknowledged. Afterwards the device acknowledges again and the data is readable.
- R8: While `wp_i` is 1, data bytes are still acknowledged but the array keeps its previous contents.
- R9: A master NACK after a read byte ends the transfer. The block then does not drive SDA until the next START.
- R10: A read device byte sent directly after a START, with no address phase, returns the byte at the address that follows the last byte transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| wp_i | input | 1 | Write protect; 1 discards all array writes |
| dev_sel_i | input | 3 | Device select bits matched against device byte bits 3:1 |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A vector table writes single bytes at low, middle and top addresses, with values of all zeros, all ones and alternating patterns. Some vectors set the ignored upper address bits, so that a truncation error separates from a correct readback. Directed sequences then try sequential reads across the top of the array and a page write that starts two bytes before a page boundary. Together they show whether the address counter wraps globally on reads but only within the page on writes. Device bytes with a wrong select field or a wrong type code, a device byte sent during the write cycle, a write under protect, and clocking with no START each have to end in a NACK or unchanged data. A master NACK followed by more clocking separates a correctly released line from one still driven.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_HOLD
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic dev_addr_hit(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_TYPE_CODE) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
    import eeprom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt,
    output logic     scl_lvl
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_now;
    logic                   sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_sync[SYNC_STAGES-1];
            sda_d    <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_now = scl_sync[SYNC_STAGES-1];
    assign sda_now = sda_sync[SYNC_STAGES-1];
    assign scl_lvl = scl_now;

    always_comb begin
        evt.scl_rise = scl_now & ~scl_d;
        evt.scl_fall = ~scl_now & scl_d;
        // data edges while the clock stays high are bus conditions
        evt.start    = scl_now & scl_d & sda_d & ~sda_now;
        evt.stop     = scl_now & scl_d & ~sda_d & sda_now;
        evt.sda      = sda_now;
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import eeprom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  bus_evt_t                 evt,
    input  logic [2:0]               dev_sel,
    input  logic                     wp,
    input  logic                     busy,
    input  logic [7:0]               rd_data,
    output logic                     sda_oe,
    output logic [ADDR_W-1:0]        ptr,
    output logic                     pb_clear,
    output logic                     pb_we,
    output logic [PAGE_W-1:0]        pb_slot,
    output logic [7:0]               pb_data,
    output logic [ADDR_W-PAGE_W-1:0] pb_base,
    output logic                     commit
);

    tgt_state_e        state;
    logic [3:0]        bitcnt;
    logic [7:0]        rx;
    logic [6:0]        tx;
    logic [7:0]        addr_hi;
    logic              rw;
    logic              mack;
    logic [ADDR_W-1:0] ptr_in_page;

    // page write advance: only the offset inside the page moves
    assign ptr_in_page = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            addr_hi  <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            pb_clear <= 1'b0;
            pb_we    <= 1'b0;
            pb_slot  <= '0;
            pb_data  <= '0;
            pb_base  <= '0;
            commit   <= 1'b0;
        end else begin
            pb_clear <= 1'b0;
            pb_we    <= 1'b0;
            commit   <= 1'b0;
            if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                commit <= 1'b1;
            end else if (evt.start) begin
                state    <= ST_DEV;
                bitcnt   <= '0;
                sda_oe   <= 1'b0;
                pb_clear <= 1'b1;
            end else begin
                unique case (state)
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (evt.scl_rise) begin
                            rx     <= {rx[6:0], evt.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.scl_fall && bitcnt == 4'd8) begin
                            unique case (state)
                                ST_DEV: begin
                                    if (dev_addr_hit(rx, dev_sel) && !busy) begin
                                        sda_oe <= 1'b1;
                                        rw     <= rx[0];
                                        state  <= ST_DEV_ACK;
                                    end else begin
                                        state <= ST_HOLD;
                                    end
                                end
                                ST_AHI: begin
                                    addr_hi <= rx;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_AHI_ACK;
                                end
                                ST_ALO: begin
                                    ptr      <= ADDR_W'({addr_hi, rx});
                                    sda_oe   <= 1'b1;
                                    pb_clear <= 1'b1;
                                    state    <= ST_ALO_ACK;
                                end
                                default: begin
                                    pb_we   <= !wp;
                                    pb_slot <= ptr[PAGE_W-1:0];
                                    pb_base <= ptr[ADDR_W-1:PAGE_W];
                                    pb_data <= rx;
                                    ptr     <= ptr_in_page;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_WDAT_ACK;
                                end
                            endcase
                        end
                    end
                    ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            unique case (state)
                                ST_DEV_ACK: begin
                                    if (rw) begin
                                        tx     <= rd_data[6:0];
                                        sda_oe <= ~rd_data[7];
                                        ptr    <= ptr + ADDR_W'(1);
                                        state  <= ST_RDAT;
                                    end else begin
                                        state <= ST_AHI;
                                    end
                                end
                                ST_AHI_ACK: state <= ST_ALO;
                                default:    state <= ST_WDAT;
                            endcase
                        end
                    end
                    ST_RDAT: begin
                        if (evt.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[6];
                                tx     <= {tx[5:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (mack) begin
                                tx     <= rd_data[6:0];
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + ADDR_W'(1);
                                state  <= ST_RDAT;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_HOLD;
                            end
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/eeprom_array_store.sv
module eeprom_array_store #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_W     = 6,
    parameter int TWR_CYCLES = 5000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pb_clear,
    input  logic                     pb_we,
    input  logic [PAGE_W-1:0]        pb_slot,
    input  logic [7:0]               pb_data,
    input  logic [ADDR_W-PAGE_W-1:0] pb_base,
    input  logic                     commit,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int BASE_W     = ADDR_W - PAGE_W;
    localparam int CNT_W      = $clog2(TWR_CYCLES) + 1;

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic [BASE_W-1:0]     page_q;
    logic [CNT_W-1:0]      tcnt;
    logic                  in_copy;
    logic [PAGE_W-1:0]     copy_slot;

    assign copy_slot = tcnt[PAGE_W-1:0];
    assign in_copy   = busy && (tcnt < CNT_W'(PAGE_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            tcnt   <= '0;
            pvalid <= '0;
            page_q <= '0;
        end else if (busy) begin
            tcnt <= tcnt + CNT_W'(1);
            if (tcnt == CNT_W'(TWR_CYCLES - 1)) begin
                busy   <= 1'b0;
                pvalid <= '0;
            end
        end else if (commit && |pvalid) begin
            busy <= 1'b1;
            tcnt <= '0;
        end else if (pb_clear) begin
            pvalid <= '0;
        end else if (pb_we) begin
            pvalid[pb_slot] <= 1'b1;
            page_q          <= pb_base;
        end
    end

    // one staged byte per cycle during the first part of the write cycle
    always_ff @(posedge clk) begin
        if (pb_we && !busy) begin
            pbuf[pb_slot] <= pb_data;
        end
        if (in_copy && pvalid[copy_slot]) begin
            mem[{page_q, copy_slot}] <= pbuf[copy_slot];
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 6,
    parameter int TWR_CYCLES  = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wp_i,
    input  logic [2:0] dev_sel_i,
    output logic       sda_oe_o
);

    localparam int BASE_W = ADDR_W - PAGE_W;

    bus_evt_t          evt;
    logic              scl_lvl;
    logic              st_busy;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] ptr;
    logic              pb_clear;
    logic              pb_we;
    logic [PAGE_W-1:0] pb_slot;
    logic [7:0]        pb_data;
    logic [BASE_W-1:0] pb_base;
    logic              commit;

    i2c_line_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .evt     (evt),
        .scl_lvl (scl_lvl)
    );

    i2c_target_fsm #(
        .ADDR_W(ADDR_W),
        .PAGE_W(PAGE_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .dev_sel  (dev_sel_i),
        .wp       (wp_i),
        .busy     (st_busy),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe_o),
        .ptr      (ptr),
        .pb_clear (pb_clear),
        .pb_we    (pb_we),
        .pb_slot  (pb_slot),
        .pb_data  (pb_data),
        .pb_base  (pb_base),
        .commit   (commit)
    );

    eeprom_array_store #(
        .ADDR_W     (ADDR_W),
        .PAGE_W     (PAGE_W),
        .TWR_CYCLES (TWR_CYCLES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .pb_clear (pb_clear),
        .pb_we    (pb_we),
        .pb_slot  (pb_slot),
        .pb_data  (pb_data),
        .pb_base  (pb_base),
        .commit   (commit),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .busy     (st_busy)
    );

endmodule

// File: rtl/eeprom_target_chk.sv
module eeprom_target_chk (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic scl_lvl,
    input logic wp,
    input logic busy,
    input logic pb_we,
    input logic commit
);

    // R1
    oe_clear_after_reset_chk: assert property (@(posedge clk)
        rst |=> !sda_oe);

    // R2
    oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_lvl));

    // R7
    no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !$rose(sda_oe));

    // R7
    busy_follows_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit));

    // R8
    no_stage_under_wp_chk: assert property (@(posedge clk) disable iff (rst)
        pb_we |-> !$past(wp));

endmodule

bind i2c_eeprom_target eeprom_target_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sda_oe  (sda_oe_o),
    .scl_lvl (scl_lvl),
    .wp      (wp_i),
    .busy    (st_busy),
    .pb_we   (pb_we),
    .commit  (commit)
);

// File: tb/tb_i2c_eeprom_target.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_target;

    localparam int AW  = 11;
    localparam int PW  = 6;
    localparam int TWR = 1000;
    localparam int Q   = 8;
    localparam logic [2:0] SEL   = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

    typedef struct packed {
        logic [15:0] wa;
        logic [15:0] ra;
        logic [7:0]  d;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 16'h0000, 8'h5A},
        '{16'h07FF, 16'h07FF, 8'hA5},
        '{16'hC123, 16'h0123, 8'h3C},
        '{16'h0400, 16'h0400, 8'h00},
        '{16'h02AA, 16'h02AA, 8'hFF},
        '{16'h3855, 16'h0055, 8'h81}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_eeprom_target #(
        .ADDR_W     (AW),
        .PAGE_W     (PW),
        .TWR_CYCLES (TWR)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_bus),
        .wp_i      (wp),
        .dev_sel_i (SEL),
        .sda_oe_o  (sda_oe)
    );

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        sda_m = 1'b0; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl = 1'b1;   wait_q(); wait_q();
            scl = 1'b0;   wait_q();
        end
        sda_m = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        ack = ~sda_bus;
        wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl = 1'b1; wait_q();
            b[i] = sda_bus;
            wait_q();
            scl = 1'b0;
        end
        sda_m = ~give_ack; wait_q();
        scl = 1'b1; wait_q(); wait_q();
        scl = 1'b0; wait_q();
        sda_m = 1'b1;
    endtask

    task automatic sel_read_open(input logic [15:0] a, output logic ok);
        logic a0, a1, a2, a3;
        bus_start();
        send_byte(DEV_W, a0);
        send_byte(a[15:8], a1);
        send_byte(a[7:0], a2);
        bus_start();
        send_byte(DEV_R, a3);
        ok = a0 & a1 & a2 & a3;
    endtask

    task automatic byte_write(input logic [15:0] a, input logic [7:0] d, output logic ok);
        logic a0, a1, a2, a3;
        bus_start();
        send_byte(DEV_W, a0);
        send_byte(a[15:8], a1);
        send_byte(a[7:0], a2);
        send_byte(d, a3);
        bus_stop();
        ok = a0 & a1 & a2 & a3;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack, ok;
        logic [7:0] b0, b1, b2;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: reset state and no reply without START
        check("R1 reset oe", {7'b0, sda_oe}, 8'h00);
        send_byte(DEV_W, ack);
        check("R1 no START ack", {7'b0, ack}, 8'h00);
        bus_stop();

        // R2: select and type code matching
        bus_start(); send_byte(8'hA0, ack); bus_stop();
        check("R2 wrong select", {7'b0, ack}, 8'h00);
        bus_start(); send_byte(8'hCA, ack); bus_stop();
        check("R2 wrong type", {7'b0, ack}, 8'h00);
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        check("R2 match", {7'b0, ack}, 8'h01);

        // R3 R4: vector table of byte write then selective read
        for (int v = 0; v < NV; v++) begin
            byte_write(VEC[v].wa, VEC[v].d, ok);
            check("R4 write acks", {7'b0, ok}, 8'h01);
            repeat (TWR + 200) @(negedge clk);
            sel_read_open(VEC[v].ra, ok);
            recv_byte(1'b0, b0);
            bus_stop();
            check("R4 read acks", {7'b0, ok}, 8'h01);
            check("R3 R4 readback", b0, VEC[v].d);
        end

        // R5: sequential read wraps from top to 0; R9: NACK releases line
        sel_read_open(16'h07FF, ok);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        recv_byte(1'b0, b2);
        bus_stop();
        check("R5 top byte", b0, 8'hA5);
        check("R5 wrapped byte", b1, 8'h5A);
        check("R9 released after NACK", b2, 8'hFF);

        // R10: immediate-address read continues after last byte
        sel_read_open(16'h07FF, ok);
        recv_byte(1'b0, b0);
        bus_stop();
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b0, b1);
        bus_stop();
        check("R10 ack", {7'b0, ack}, 8'h01);
        check("R10 next byte", b1, 8'h5A);

        // R6 R7: page write across page end, busy nack
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h01, ack);
        send_byte(8'h3E, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        send_byte(8'h44, ack);
        bus_stop();
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        check("R7 nack while busy", {7'b0, ack}, 8'h00);
        repeat (TWR + 200) @(negedge clk);
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        check("R7 ack after cycle", {7'b0, ack}, 8'h01);
        sel_read_open(16'h013E, ok);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        bus_stop();
        check("R6 offset 3E", b0, 8'h11);
        check("R6 offset 3F", b1, 8'h22);
        sel_read_open(16'h0100, ok);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        bus_stop();
        check("R6 wrapped offset 00", b0, 8'h33);
        check("R6 wrapped offset 01", b1, 8'h44);

        // R8: protected write acked but discarded
        wp = 1'b1;
        byte_write(16'h0000, 8'h77, ok);
        wp = 1'b0;
        check("R8 acks under protect", {7'b0, ok}, 8'h01);
        repeat (TWR + 200) @(negedge clk);
        sel_read_open(16'h0000, ok);
        recv_byte(1'b0, b0);
        bus_stop();
        check("R8 data unchanged", b0, 8'h5A);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule